// File: doc/BRIEF.md
# Output Port Cell Address Queue

This block sits in one output port of a shared-memory cell switch. Every cell that enters the switch is announced on a broadcast arrival bus. The announcement carries the cell's circuit number and the location of the cell in common memory. The block snoops that bus and looks the circuit up in a per-port membership table. When the circuit leaves through this port, the block queues only the memory location of the cell, together with its circuit number. It never stores the cell data.

When the port's transmitter asks for the next cell, the block pops the oldest entry. It presents the stored address to the common-memory read side. In the same cycle it announces the circuit of the departing cell on the shared departure bus, so that input ports can keep their per-circuit buffer counts. The membership table is loaded through a simple write port. The queue has a fixed depth. An arrival that finds the queue full is lost, and a sticky flag records the loss.

Top module: `oq_cell_addr_queue`

## Requirements
- R1: After reset the queue is empty, the overflow flag is 0, and every membership table bit is 0. No circuit exits the port.
- R2: An arrival is queued only when `arr_valid` is 1 and the table bit at index `arr_vc` is 1. All other arrivals leave the queue unchanged.
- R3: The queue holds 256 entries. If an accepted arrival meets a full queue with no pop in that cycle, it is dropped, the stored contents are unchanged, and `ovf_flag` goes to 1 on the next cycle. The flag stays at 1 until reset.
- R4: Queued cells leave in arrival order, and `rd_addr` carries the memory address given with the arrival.
- R5: For each dequeued cell, `dep_valid` is 1 for exactly that one cycle, the same cycle as `rd_valid`. `dep_vc` carries that cell's circuit number.
- R6: `tx_req` on an empty queue produces neither `rd_valid` nor `dep_valid`.
- R7: An arrival and a pop in the same cycle both take effect. An arrival into an empty queue is not visible on `rd_valid` until the following cycle.
- R8: A table write (`cfg_we`, `cfg_vc`, `cfg_exit`) governs arrivals from the next cycle on. An arrival in the same cycle as the write uses the old bit. Writing 0 removes a circuit.
- R9: When the queue is full and a pop happens in the same cycle as an accepted arrival, the arrival is queued and `ovf_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Membership table write strobe |
| cfg_vc | input | 10 | Circuit index to write |
| cfg_exit | input | 1 | 1: circuit leaves through this port |
| arr_valid | input | 1 | Arrival bus carries a cell this cycle |
| arr_vc | input | 10 | Circuit number of the arriving cell |
| arr_addr | input | 16 | Common-memory location of the arriving cell |
| tx_req | input | 1 | Transmitter requests the next cell |
| rd_valid | output | 1 | Memory read of `rd_addr` is requested |
| rd_addr | output | 16 | Address of the departing cell |
| dep_valid | output | 1 | Departure bus carries a circuit this cycle |
| dep_vc | output | 10 | Circuit number of the departing cell |
| ovf_flag | output | 1 | Sticky: an accepted arrival was lost |

## Verification
The bench targets three corner cases:
- **Arrival and request on an empty queue.** A design that forwards the arrival straight through would show `rd_valid` a cycle early.
- **A full queue that is popped in the same cycle as an arrival.** A design that checks fullness without regard to the pop would drop the cell and raise the flag. A design that ignores fullness entirely would overwrite the head.
- **A table write that coincides with an arrival on the same circuit.** A table that bypasses the write would accept a cell that should be lost.

Lastly, the bench drains a queue that has overflowed and compares every address. Any corruption of the stored order, or a dropped cell that reappears, shows up as a mismatch.

// File: rtl/oq_pkg.sv
package oq_pkg;
    localparam int VC_W    = 10;
    localparam int NUM_VC  = 1 << VC_W;
    localparam int MADDR_W = 16;
    localparam int Q_DEPTH = 256;

    typedef logic [VC_W-1:0]    vc_t;
    typedef logic [MADDR_W-1:0] maddr_t;

    typedef struct packed {
        vc_t    vc;
        maddr_t addr;
    } qentry_t;

    function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/oq_circuit_map.sv
module oq_circuit_map
    import oq_pkg::*;
#(
    parameter int N = NUM_VC
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  vc_t  wr_idx,
    input  logic wr_bit,
    input  vc_t  rd_idx,
    output logic rd_bit
);
    logic [N-1:0] exits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exits_q <= '0;
        end else if (wr_en) begin
            exits_q[wr_idx] <= wr_bit;
        end
    end

    // Read returns the stored bit; a write in this cycle is seen next cycle.
    assign rd_bit = exits_q[rd_idx];
endmodule

// File: rtl/oq_addr_fifo.sv
module oq_addr_fifo
    import oq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  qentry_t push_data,
    input  logic    pop,
    output qentry_t head,
    output logic    empty,
    output logic    full
);
    qentry_t         mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= PW'(ptr_next(32'(wr_ptr), DEPTH));
            if (pop)  rd_ptr <= PW'(ptr_next(32'(rd_ptr), DEPTH));
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_push_full_needs_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_count_track_r7: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count));
endmodule

// File: rtl/oq_cell_addr_queue.sv
module oq_cell_addr_queue
    import oq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [VC_W-1:0]    cfg_vc,
    input  logic               cfg_exit,
    input  logic               arr_valid,
    input  logic [VC_W-1:0]    arr_vc,
    input  logic [MADDR_W-1:0] arr_addr,
    input  logic               tx_req,
    output logic               rd_valid,
    output logic [MADDR_W-1:0] rd_addr,
    output logic               dep_valid,
    output logic [VC_W-1:0]    dep_vc,
    output logic               ovf_flag
);
    logic    vc_exits;
    logic    accept, push, pop, q_empty, q_full;
    qentry_t head, wdata;
    logic    ovf_q;

    oq_circuit_map #(.N(NUM_VC)) u_map (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_idx (cfg_vc),
        .wr_bit (cfg_exit),
        .rd_idx (arr_vc),
        .rd_bit (vc_exits)
    );

    assign accept = arr_valid && vc_exits;
    assign pop    = tx_req && !q_empty;
    assign push   = accept && (!q_full || pop);
    assign wdata  = '{vc: arr_vc, addr: arr_addr};

    oq_addr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (wdata),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                 ovf_q <= 1'b0;
        else if (accept && !push) ovf_q <= 1'b1;
    end

    assign rd_valid  = pop;
    assign rd_addr   = head.addr;
    assign dep_valid = pop;
    assign dep_vc    = head.vc;
    assign ovf_flag  = ovf_q;

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);
    p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (arr_valid && vc_exits && q_full && !tx_req) |=> ovf_flag);
    p_no_read_when_empty_r6: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !rd_valid && !dep_valid);
    p_filter_r2: assert property (@(posedge clk) disable iff (rst)
        (q_empty && !(arr_valid && vc_exits)) |=> q_empty);
endmodule

// File: tb/sim_oq_cell_addr_queue.sv
module sim_oq_cell_addr_queue;
    import oq_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_exit, arr_valid, tx_req;
    logic [VC_W-1:0] cfg_vc, arr_vc;
    logic [MADDR_W-1:0] arr_addr;
    logic rd_valid, dep_valid, ovf_flag;
    logic [MADDR_W-1:0] rd_addr;
    logic [VC_W-1:0] dep_vc;

    int checks = 0;
    int fails  = 0;

    // bench model, built from the requirements
    logic          map_m [NUM_VC];
    logic [25:0]   q_m [$];
    logic          ovf_m;

    always #10 clk = ~clk;

    oq_cell_addr_queue u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_exit(cfg_exit),
        .arr_valid(arr_valid), .arr_vc(arr_vc), .arr_addr(arr_addr), .tx_req(tx_req),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .dep_valid(dep_valid), .dep_vc(dep_vc),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, sample, compare, then clock.
    task automatic step(input bit av, input int vc, input int addr, input bit tx,
                        input bit cw, input int cvc, input bit cbit, input string req);
        bit exp_pop;
        logic [25:0] e;
        @(negedge clk);
        arr_valid = av; arr_vc = VC_W'(vc); arr_addr = MADDR_W'(addr); tx_req = tx;
        cfg_we = cw; cfg_vc = VC_W'(cvc); cfg_exit = cbit;
        #2;
        exp_pop = tx && (q_m.size() != 0);
        chk(rd_valid == exp_pop, {req, " rd_valid"}, rd_valid, exp_pop);
        chk(dep_valid == rd_valid, {req, " R5 dep_valid"}, dep_valid, rd_valid);
        chk(ovf_flag == ovf_m, {req, " R3 ovf_flag"}, ovf_flag, ovf_m);
        if (exp_pop) begin
            e = q_m.pop_front();
            chk(rd_addr == e[15:0], {req, " R4 rd_addr"}, rd_addr, e[15:0]);
            chk(dep_vc == e[25:16], {req, " R5 dep_vc"}, dep_vc, e[25:16]);
        end
        if (av && map_m[vc]) begin
            if (q_m.size() < Q_DEPTH) q_m.push_back({10'(vc), 16'(addr)});
            else ovf_m = 1'b1;
        end
        if (cw) map_m[cvc] = cbit;
        @(posedge clk);
    endtask

    task automatic idle(input bit tx, input string req);
        step(0, 0, 0, tx, 0, 0, 0, req);
    endtask

    task automatic cfg(input int vc, input bit b);
        step(0, 0, 0, 0, 1, vc, b, "R8");
    endtask

    task automatic t_reset;
        step(1, 5, 16'h1111, 0, 0, 0, 0, "R1");   // no circuit mapped yet
        step(1, 1023, 16'h2222, 1, 0, 0, 0, "R1");
        idle(1, "R6");
        chk(q_m.size() == 0, "R1 model", q_m.size(), 0);
    endtask

    task automatic t_filter_order;
        cfg(5, 1); cfg(1023, 1);
        step(1, 5, 16'hA001, 0, 0, 0, 0, "R2");
        step(1, 7, 16'hB002, 0, 0, 0, 0, "R2");
        step(0, 5, 16'hC003, 0, 0, 0, 0, "R2");
        step(1, 1023, 16'hD004, 0, 0, 0, 0, "R2");
        idle(1, "R4"); idle(0, "R5"); idle(1, "R4"); idle(1, "R6");
    endtask

    task automatic t_same_cycle;
        step(1, 5, 16'h0E01, 1, 0, 0, 0, "R7");   // empty: no pop this cycle
        step(1, 5, 16'h0E02, 1, 0, 0, 0, "R7");   // pop E01 and push E02
        idle(1, "R7"); idle(1, "R6");
    endtask

    task automatic t_cfg_timing;
        step(1, 9, 16'h0901, 0, 1, 9, 1, "R8");   // uses old bit: dropped
        step(1, 9, 16'h0902, 0, 0, 0, 0, "R8");
        cfg(9, 0);
        step(1, 9, 16'h0903, 0, 0, 0, 0, "R8");
        idle(1, "R8"); idle(1, "R8");
    endtask

    task automatic t_full;
        for (int i = 0; i < Q_DEPTH; i++) step(1, 1023, 16'h4000 + i, 0, 0, 0, 0, "R3");
        step(1, 5, 16'h5000, 1, 0, 0, 0, "R9");   // full + pop: accepted
        idle(0, "R9");
        step(1, 5, 16'h5001, 0, 0, 0, 0, "R3");   // full, no pop: dropped
        idle(0, "R3");
        for (int i = 0; i < Q_DEPTH; i++) idle(1, "R4");
        idle(1, "R3");
        chk(ovf_m == 1'b1, "R3 model", ovf_m, 1);
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (map_m[i]) map_m[i] = 1'b0;
        ovf_m = 1'b0;
        rst = 1'b1; cfg_we = 0; cfg_vc = '0; cfg_exit = 0;
        arr_valid = 0; arr_vc = '0; arr_addr = '0; tx_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_filter_order();
        t_same_cycle();
        t_cfg_timing();
        t_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule